// File: doc/BRIEF.md
# Banked Double-Word Block Mover

This block copies a run of 32-bit units, each made of two 16-bit words, from a source region to a destination region of a memory organised as four banks. A controller issues one start command. The command carries an even destination address, an even source address, a count in double-words, a 4-bit bank selector and the caller's program counter. The mover first captures the bank-register value in force. It then programs that register with the destination and source banks from the selector. Next it loops: it reads two source words and writes them to two destination words. On every exit path it writes the captured bank value back.

Between double-words the mover polls a pending-interrupt input. If an interrupt is pending, the mover stops before the next pair. It leaves the address and count outputs at their progress point and steps the program counter back by one. The caller can then re-issue the same command from those outputs and the copy resumes where it stopped. A suspended exit shows a separate status so the controller can tell it apart from completion. A start with an odd address is refused with an error flag.

Top module: `dword_bank_mover`

## Requirements
- R1: A start whose destination or source address has bit 0 set sets `error` and `done` on the edge that accepts it. It makes no memory request and no bank-register write, and `busy` stays low.
- R2: Each double-word is moved in this order: a read of source address A, a read of A+1, a write of the first word read to destination address D, and a write of the second word read to D+1. No other memory request is made.
- R3: `dw_count` falls by one after each pair is written. The copy completes when the count reaches zero.
- R4: Reads use bank `cmd_sel[1:0]` and writes use bank `cmd_sel[3:2]`.
- R5: The value on `cur_bank_cfg` at the accepting edge is saved. The first bank-register write (`bank_wr_en` high, one cycle after the accepting edge) carries `cmd_sel`. The last bank-register write, on both completion and suspension, carries the saved value.
- R6: `src_addr` and `dst_addr` each advance by 2 after each pair is written, and are visible on the ports.
- R7: `irq_pending` is sampled before each pair. If it is high and the count is non-zero, the mover makes no further memory request, `src_addr` and `dw_count` keep their values, and `resume_pc` drops by one.
- R8: A suspended exit sets `suspended` and leaves `done` low. A completed exit sets `done` and leaves `suspended` low. The two are never high together.
- R9: A start with a count of zero makes no memory request, still writes `cmd_sel` and then the saved value to the bank register, and sets `done` three edges after the accepting edge.
- R10: `cmd_start` is ignored while `busy` is high.
- R11: A memory request that is not accepted (`mem_req_ready` low) is held with unchanged bank, address, write enable and data until it is accepted. Read data is taken when `mem_rsp_valid` is high.
- R12: A zero count takes priority over a pending interrupt: the exit is a completion, not a suspension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Start pulse, taken only while idle |
| cmd_dst | input | 16 | First destination address (even) |
| cmd_src | input | 16 | First source address (even) |
| cmd_count | input | 16 | Number of double-words to move |
| cmd_sel | input | 4 | Bank selector: [3:2] destination, [1:0] source |
| cmd_pc | input | 16 | Caller program counter |
| cur_bank_cfg | input | 4 | Bank-register value currently in force |
| irq_pending | input | 1 | Pending-interrupt indication |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_bank | output | 2 | Bank of the request |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| bank_wr_en | output | 1 | Bank-register write strobe |
| bank_wr_val | output | 4 | Value written to the bank register |
| dst_addr | output | 16 | Current destination address |
| src_addr | output | 16 | Current source address |
| dw_count | output | 16 | Remaining double-word count |
| resume_pc | output | 16 | Program counter to hand back to the caller |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Last command completed (held until next start) |
| suspended | output | 1 | Last command stopped on an interrupt (held until next start) |
| error | output | 1 | Last command refused for an odd address |

## Verification
The timing of each result is fixed relative to the edge that accepts `cmd_start`. An odd-address refusal is visible right after that edge. The programming write of the bank register is on the port in the following cycle. A zero-count command shows its restore write two cycles after the programming write and `done` one cycle later. The bench samples at the falling edge and checks exactly those cycles. A non-zero copy depends on memory stalls, so the bench does not count cycles for it. Instead it matches every accepted memory request and every bank-register write, in the falling-edge sample before the accepting edge, against queues of expected transactions. It checks the register outputs and status once `busy` falls. A suspension is provoked by raising `irq_pending` in the cycle of the first pair's last write, so exactly one pair must be committed.

// File: rtl/mover_pkg.sv
package mover_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_CHECK,
    ST_RD0,
    ST_W0,
    ST_RD1,
    ST_W1,
    ST_WR0,
    ST_WR1,
    ST_RESTORE
  } mv_state_e;

  typedef enum logic [2:0] {
    RQ_NONE,
    RQ_RD0,
    RQ_RD1,
    RQ_WR0,
    RQ_WR1
  } mv_req_e;

endpackage

// File: rtl/mover_fsm.sv
module mover_fsm
  import mover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ops_odd,
  input  logic       cnt_zero,
  input  logic       irq_pending,
  input  logic       req_ready,
  input  logic       rsp_valid,
  output mv_req_e    req_kind,
  output logic       load_ops,
  output logic [1:0] cap,
  output logic       pair_commit,
  output logic       susp_evt,
  output logic       bank_wr_en,
  output logic       bank_restore,
  output logic       busy,
  output logic       done,
  output logic       suspended,
  output logic       error
);

  mv_state_e state_q, state_d;
  logic      susp_pend_q;
  logic      take_start;

  assign take_start = (state_q == ST_IDLE) && start;
  assign load_ops   = take_start && !ops_odd;
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_d      = state_q;
    req_kind     = RQ_NONE;
    cap          = 2'b00;
    pair_commit  = 1'b0;
    susp_evt     = 1'b0;
    bank_wr_en   = 1'b0;
    bank_restore = 1'b0;
    case (state_q)
      ST_IDLE:    if (load_ops) state_d = ST_PROG;
      ST_PROG: begin
        bank_wr_en = 1'b1;
        state_d    = ST_CHECK;
      end
      ST_CHECK: begin
        if (cnt_zero) begin
          state_d = ST_RESTORE;
        end else if (irq_pending) begin
          susp_evt = 1'b1;
          state_d  = ST_RESTORE;
        end else begin
          state_d = ST_RD0;
        end
      end
      ST_RD0: begin
        req_kind = RQ_RD0;
        if (req_ready) state_d = ST_W0;
      end
      ST_W0: begin
        cap[0] = rsp_valid;
        if (rsp_valid) state_d = ST_RD1;
      end
      ST_RD1: begin
        req_kind = RQ_RD1;
        if (req_ready) state_d = ST_W1;
      end
      ST_W1: begin
        cap[1] = rsp_valid;
        if (rsp_valid) state_d = ST_WR0;
      end
      ST_WR0: begin
        req_kind = RQ_WR0;
        if (req_ready) state_d = ST_WR1;
      end
      ST_WR1: begin
        req_kind    = RQ_WR1;
        pair_commit = req_ready;
        if (req_ready) state_d = ST_CHECK;
      end
      ST_RESTORE: begin
        bank_wr_en   = 1'b1;
        bank_restore = 1'b1;
        state_d      = ST_IDLE;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      susp_pend_q <= 1'b0;
      done        <= 1'b0;
      suspended   <= 1'b0;
      error       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_start) begin
        done        <= ops_odd;
        error       <= ops_odd;
        suspended   <= 1'b0;
        susp_pend_q <= 1'b0;
      end else if (susp_evt) begin
        susp_pend_q <= 1'b1;
      end else if (state_q == ST_RESTORE) begin
        done        <= !susp_pend_q;
        suspended   <= susp_pend_q;
        susp_pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mover_datapath.sv
module mover_datapath
  import mover_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int BW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_ops,
  input  logic [AW-1:0]   cmd_dst,
  input  logic [AW-1:0]   cmd_src,
  input  logic [CW-1:0]   cmd_count,
  input  logic [2*BW-1:0] cmd_sel,
  input  logic [AW-1:0]   cmd_pc,
  input  logic [2*BW-1:0] cur_bank_cfg,
  input  logic [1:0]      cap,
  input  logic [DW-1:0]   rsp_data,
  input  logic            pair_commit,
  input  logic            susp_evt,
  input  mv_req_e         req_kind,
  input  logic            bank_restore,
  output logic            ops_odd,
  output logic            cnt_zero,
  output logic [AW-1:0]   dst_q,
  output logic [AW-1:0]   src_q,
  output logic [CW-1:0]   cnt_q,
  output logic [AW-1:0]   pc_q,
  output logic [2*BW-1:0] sel_q,
  output logic [2*BW-1:0] bank_wr_val,
  output logic            req_valid,
  output logic [BW-1:0]   req_bank,
  output logic [AW-1:0]   req_addr,
  output logic            req_we,
  output logic [DW-1:0]   req_wdata
);

  localparam int SELW = 2 * BW;

  function automatic logic [AW-1:0] f_pair_step(input logic [AW-1:0] a);
    return a + AW'(2);
  endfunction

  function automatic logic [AW-1:0] f_second(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] f_back_pc(input logic [AW-1:0] p);
    return p - AW'(1);
  endfunction

  function automatic logic [CW-1:0] f_cnt_dec(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic [BW-1:0] f_dst_bank(input logic [SELW-1:0] s);
    return s[SELW-1:BW];
  endfunction

  function automatic logic [BW-1:0] f_src_bank(input logic [SELW-1:0] s);
    return s[BW-1:0];
  endfunction

  logic [SELW-1:0]        save_q;
  logic [1:0][DW-1:0]     pair_w;

  assign ops_odd  = cmd_dst[0] | cmd_src[0];
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src_q  <= '0;
      cnt_q  <= '0;
      pc_q   <= '0;
      sel_q  <= '0;
      save_q <= '0;
    end else if (load_ops) begin
      dst_q  <= cmd_dst;
      src_q  <= cmd_src;
      cnt_q  <= cmd_count;
      pc_q   <= cmd_pc;
      sel_q  <= cmd_sel;
      save_q <= cur_bank_cfg;
    end else if (pair_commit) begin
      dst_q <= f_pair_step(dst_q);
      src_q <= f_pair_step(src_q);
      cnt_q <= f_cnt_dec(cnt_q);
    end else if (susp_evt) begin
      pc_q <= f_back_pc(pc_q);
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (cap[gi]) word_q <= rsp_data;
    end
    assign pair_w[gi] = word_q;
  end

  assign bank_wr_val = bank_restore ? save_q : sel_q;

  always_comb begin
    req_valid = 1'b1;
    req_bank  = f_src_bank(sel_q);
    req_addr  = src_q;
    req_we    = 1'b0;
    req_wdata = '0;
    case (req_kind)
      RQ_RD0: req_addr = src_q;
      RQ_RD1: req_addr = f_second(src_q);
      RQ_WR0: begin
        req_bank  = f_dst_bank(sel_q);
        req_addr  = dst_q;
        req_we    = 1'b1;
        req_wdata = pair_w[0];
      end
      RQ_WR1: begin
        req_bank  = f_dst_bank(sel_q);
        req_addr  = f_second(dst_q);
        req_we    = 1'b1;
        req_wdata = pair_w[1];
      end
      default: req_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/dword_bank_mover.sv
module dword_bank_mover
  import mover_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int BW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic [AW-1:0]   cmd_dst,
  input  logic [AW-1:0]   cmd_src,
  input  logic [CW-1:0]   cmd_count,
  input  logic [2*BW-1:0] cmd_sel,
  input  logic [AW-1:0]   cmd_pc,
  input  logic [2*BW-1:0] cur_bank_cfg,
  input  logic            irq_pending,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [BW-1:0]   mem_req_bank,
  output logic [AW-1:0]   mem_req_addr,
  output logic            mem_req_we,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            bank_wr_en,
  output logic [2*BW-1:0] bank_wr_val,
  output logic [AW-1:0]   dst_addr,
  output logic [AW-1:0]   src_addr,
  output logic [CW-1:0]   dw_count,
  output logic [AW-1:0]   resume_pc,
  output logic            busy,
  output logic            done,
  output logic            suspended,
  output logic            error
);

  localparam int SELW = 2 * BW;

  // named internal events, also watched by the checker
  mv_req_e         req_kind;
  logic            load_ops;
  logic [1:0]      cap;
  logic            pair_commit;
  logic            susp_evt;
  logic            bank_restore;
  logic            ops_odd;
  logic            cnt_zero;
  logic [SELW-1:0] sel_q;

  mover_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (cmd_start),
    .ops_odd      (ops_odd),
    .cnt_zero     (cnt_zero),
    .irq_pending  (irq_pending),
    .req_ready    (mem_req_ready),
    .rsp_valid    (mem_rsp_valid),
    .req_kind     (req_kind),
    .load_ops     (load_ops),
    .cap          (cap),
    .pair_commit  (pair_commit),
    .susp_evt     (susp_evt),
    .bank_wr_en   (bank_wr_en),
    .bank_restore (bank_restore),
    .busy         (busy),
    .done         (done),
    .suspended    (suspended),
    .error        (error)
  );

  mover_datapath #(.AW(AW), .DW(DW), .CW(CW), .BW(BW)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_ops     (load_ops),
    .cmd_dst      (cmd_dst),
    .cmd_src      (cmd_src),
    .cmd_count    (cmd_count),
    .cmd_sel      (cmd_sel),
    .cmd_pc       (cmd_pc),
    .cur_bank_cfg (cur_bank_cfg),
    .cap          (cap),
    .rsp_data     (mem_rsp_data),
    .pair_commit  (pair_commit),
    .susp_evt     (susp_evt),
    .req_kind     (req_kind),
    .bank_restore (bank_restore),
    .ops_odd      (ops_odd),
    .cnt_zero     (cnt_zero),
    .dst_q        (dst_addr),
    .src_q        (src_addr),
    .cnt_q        (dw_count),
    .pc_q         (resume_pc),
    .sel_q        (sel_q),
    .bank_wr_val  (bank_wr_val),
    .req_valid    (mem_req_valid),
    .req_bank     (mem_req_bank),
    .req_addr     (mem_req_addr),
    .req_we       (mem_req_we),
    .req_wdata    (mem_req_wdata)
  );

endmodule

// File: rtl/mover_checker.sv
module mover_checker #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int BW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            suspended,
  input logic            error,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [BW-1:0]   mem_req_bank,
  input logic [AW-1:0]   mem_req_addr,
  input logic            mem_req_we,
  input logic [DW-1:0]   mem_req_wdata,
  input logic            bank_wr_en,
  input logic [AW-1:0]   src_addr,
  input logic [AW-1:0]   dst_addr,
  input logic [CW-1:0]   dw_count,
  input logic [AW-1:0]   resume_pc,
  input logic [2*BW-1:0] sel_q,
  input logic            pair_commit,
  input logic            susp_evt
);

  p_odd_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done && !suspended);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_commit |=> dw_count == $past(dw_count) - CW'(1));

  p_read_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> mem_req_bank == sel_q[BW-1:0]);

  p_write_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_bank == sel_q[2*BW-1:BW]);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_commit |=> (src_addr == $past(src_addr) + AW'(2))
                 && (dst_addr == $past(dst_addr) + AW'(2)));

  p_suspend_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |=> (resume_pc == $past(resume_pc) - AW'(1))
              && $stable(src_addr) && $stable(dw_count));

  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !bank_wr_en);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid
      && $stable(mem_req_bank) && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

endmodule

bind dword_bank_mover mover_checker #(.AW(AW), .DW(DW), .CW(CW), .BW(BW)) u_mover_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .suspended     (suspended),
  .error         (error),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_bank  (mem_req_bank),
  .mem_req_addr  (mem_req_addr),
  .mem_req_we    (mem_req_we),
  .mem_req_wdata (mem_req_wdata),
  .bank_wr_en    (bank_wr_en),
  .src_addr      (src_addr),
  .dst_addr      (dst_addr),
  .dw_count      (dw_count),
  .resume_pc     (resume_pc),
  .sel_q         (sel_q),
  .pair_commit   (pair_commit),
  .susp_evt      (susp_evt)
);

// File: tb/tb_dword_bank_mover.sv
`timescale 1ns/1ps
module tb_dword_bank_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [15:0] cmd_dst = '0, cmd_src = '0, cmd_count = '0, cmd_pc = '0;
  logic [3:0]  cmd_sel = '0, cur_bank_cfg = '0;
  logic        irq_pending = 1'b0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [1:0]  mem_req_bank;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        bank_wr_en;
  logic [3:0]  bank_wr_val;
  logic [15:0] dst_addr, src_addr, dw_count, resume_pc;
  logic        busy, done, suspended, error;

  always #10 clk = ~clk;

  dword_bank_mover dut (.*);

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  bit finished = 1'b0;
  bit stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [15:0] mem [4][256];
  logic [39:0] exp_req[$];
  logic [3:0]  exp_bank[$];

  function automatic logic [15:0] pat(input int b, input int a);
    return 16'((b * 16'h1111) ^ (a * 16'h0101) ^ 16'h5A3C);
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_bank][mem_req_addr[7:0]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_bank][mem_req_addr[7:0]];
      end
    end
  end

  // transaction monitor (R2, R4, R5, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) chk("R2 unexpected request", {mem_req_bank, mem_req_we, mem_req_addr, mem_req_wdata}, '1);
        else chk("R2/R4/R11 request", {2'b00, mem_req_bank, mem_req_we, 3'b000, mem_req_addr, mem_req_we ? mem_req_wdata : 16'h0}, exp_req.pop_front());
        if (mem_req_we) wr_seen++;
      end
      if (bank_wr_en) begin
        if (exp_bank.size() == 0) chk("R5 unexpected bank write", 40'(bank_wr_val), '1);
        else chk("R5 bank write", 40'(bank_wr_val), 40'(exp_bank.pop_front()));
      end
    end
  end

  function automatic logic [39:0] pk(input int b, input bit we, input int a, input logic [15:0] d);
    return {2'b00, 2'(b), we, 3'b000, 16'(a), we ? d : 16'h0};
  endfunction

  task automatic push_pairs(input int sb, input int db, input int s, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_req.push_back(pk(sb, 1'b0, s + 2*i, 16'h0));
      exp_req.push_back(pk(sb, 1'b0, s + 2*i + 1, 16'h0));
      exp_req.push_back(pk(db, 1'b1, d + 2*i, pat(sb, s + 2*i)));
      exp_req.push_back(pk(db, 1'b1, d + 2*i + 1, pat(sb, s + 2*i + 1)));
    end
  endtask

  task automatic issue(input logic [15:0] d, input logic [15:0] s, input logic [15:0] c,
                       input logic [3:0] sel, input logic [15:0] pc);
    @(negedge clk);
    cmd_dst = d; cmd_src = s; cmd_count = c; cmd_sel = sel; cmd_pc = pc;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 256; a++) mem[b][a] = pat(b, a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset busy/done/susp/err", {busy, done, suspended, error}, 0);
    chk("reset mem_req_valid R11", 40'(mem_req_valid), 0);
    chk("reset bank_wr_en R5", 40'(bank_wr_en), 0);

    // A: 3 pairs, src bank 1 -> dst bank 2, start while busy ignored (R10)
    cur_bank_cfg = 4'hA;
    exp_bank.push_back(4'h9); exp_bank.push_back(4'hA);
    push_pairs(1, 2, 16'h0010, 16'h0080, 3);
    issue(16'h0080, 16'h0010, 16'd3, 4'h9, 16'h0400);
    chk("R5 program write one cycle after start", {bank_wr_en, bank_wr_val}, {1'b1, 4'h9});
    repeat (4) @(negedge clk);
    cmd_dst = 16'h0001; cmd_src = 16'h0003; cmd_count = 16'd9; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    chk("R3 count zero at end", 40'(dw_count), 0);
    chk("R6 src advanced", 40'(src_addr), 40'h0016);
    chk("R6 dst advanced", 40'(dst_addr), 40'h0086);
    chk("R10 busy start ignored: status", {done, suspended, error}, 3'b100);
    chk("R8 pc kept on completion", 40'(resume_pc), 40'h0400);
    chk("R2 all transactions seen", 40'(exp_req.size() + exp_bank.size()), 0);
    for (int i = 0; i < 6; i++)
      chk("R2 destination contents", 40'(mem[2][8'h80 + i]), 40'(pat(1, 16 + i)));

    // B: count zero (R9) with irq high (R12)
    cur_bank_cfg = 4'h3;
    irq_pending = 1'b1;
    exp_bank.push_back(4'h6); exp_bank.push_back(4'h3);
    issue(16'h00A0, 16'h0020, 16'd0, 4'h6, 16'h0500);
    chk("R9 program write", {bank_wr_en, bank_wr_val}, {1'b1, 4'h6});
    @(negedge clk);
    @(negedge clk);
    chk("R9 restore write", {bank_wr_en, bank_wr_val, done}, {1'b1, 4'h3, 1'b0});
    @(negedge clk);
    chk("R9 R12 done not suspended", {busy, done, suspended, error}, 4'b0100);
    chk("R12 pc kept", 40'(resume_pc), 40'h0500);
    irq_pending = 1'b0;

    // C: odd addresses refused (R1)
    issue(16'h00A0, 16'h0021, 16'd2, 4'h6, 16'h0500);
    chk("R1 odd src refused", {busy, done, suspended, error, bank_wr_en, mem_req_valid}, 6'b010100);
    issue(16'h00A1, 16'h0020, 16'd2, 4'h6, 16'h0500);
    chk("R1 odd dst refused", {busy, done, suspended, error, bank_wr_en, mem_req_valid}, 6'b010100);
    repeat (3) @(negedge clk);
    chk("R1 no transactions", 40'(exp_req.size() + exp_bank.size()), 0);

    // D: memory stalls (R11), src bank 0 -> dst bank 3 (R4)
    stall_mode = 1'b1;
    cur_bank_cfg = 4'h5;
    exp_bank.push_back(4'hC); exp_bank.push_back(4'h5);
    push_pairs(0, 3, 16'h0030, 16'h00C0, 4);
    issue(16'h00C0, 16'h0030, 16'd4, 4'hC, 16'h0600);
    wait_idle();
    stall_mode = 1'b0;
    chk("R11 stalled copy complete", {done, suspended, error}, 3'b100);
    chk("R3 R6 stalled end regs", {dw_count[7:0], src_addr, dst_addr}, {8'd0, 16'h0038, 16'h00C8});
    chk("R11 all transactions seen", 40'(exp_req.size() + exp_bank.size()), 0);

    // E: suspension after one pair (R7, R8), then resume
    cur_bank_cfg = 4'h1;
    exp_bank.push_back(4'hB); exp_bank.push_back(4'h1);
    push_pairs(3, 2, 16'h0040, 16'h00E0, 1);
    wr_seen = 0;
    issue(16'h00E0, 16'h0040, 16'd4, 4'hB, 16'h0700);
    for (int i = 0; i < 200 && wr_seen < 2; i++) @(negedge clk);
    irq_pending = 1'b1;
    wait_idle();
    irq_pending = 1'b0;
    chk("R8 suspended not done", {done, suspended, error}, 3'b010);
    chk("R7 pc stepped back", 40'(resume_pc), 40'h06FF);
    chk("R7 src/dst/count after one pair", {dw_count, src_addr, dst_addr}, {16'd3, 16'h0042, 16'h00E2});
    chk("R7 R5 no further transactions", 40'(exp_req.size() + exp_bank.size()), 0);
    exp_bank.push_back(4'hB); exp_bank.push_back(4'h1);
    push_pairs(3, 2, 16'h0042, 16'h00E2, 3);
    issue(dst_addr, src_addr, dw_count, 4'hB, resume_pc);
    wait_idle();
    chk("R8 resumed copy done", {done, suspended, error}, 3'b100);
    chk("R3 resumed count", 40'(dw_count), 0);
    for (int i = 0; i < 8; i++)
      chk("R2 resumed destination contents", 40'(mem[2][8'hE0 + i]), 40'(pat(3, 64 + i)));
    chk("R5 resume transactions seen", 40'(exp_req.size() + exp_bank.size()), 0);

    finish_run();
  end

endmodule